// File: doc/BRIEF.md
# Sign-Magnitude Scaled Amplitude Stage

This block sets the amplitude of one synthesized output channel. Software writes a 16-bit scale word through a simple write strobe in the register clock domain. The word is in sign-magnitude fixed point with one sign bit, one integer bit and fourteen fraction bits. The block turns that word into two's complement in the register domain and holds it there. It then moves the whole word into the sample clock domain under a toggle handshake.

In the sample domain, every incoming full-scale signed sample is multiplied by the converted scale. The product is shifted back to sample scale, rounded, and clamped to the 16-bit signed range. The result leaves through a valid-qualified sample port after a fixed pipeline delay. The scale is meant to change rarely, so there is no per-cycle update path.

Top module: `amp_scale_stage`

## Requirements
- R1: A scale word is sign-magnitude 1.1.14. Bit 15 is the sign and bits 14:0 are the magnitude, with 14 fraction bits. The effective scale is the magnitude divided by 16384, negated when bit 15 is 1. For example, 0xA000 scales by -0.5 and 0x7FFF scales by 32767/16384.
- R2: The negative-zero word 0x8000 acts as a scale of zero, so every valid output sample is 0.
- R3: A word is taken when reg_wr is high at a rising edge of reg_clk. The converted scale holds its value while reg_wr is low.
- R4: After reset the scale is +1.0 (0x4000) in both clock domains, so valid samples pass through unchanged.
- R5: A written scale is applied to samples as one complete word. This happens within six rising edges of smp_clk after the accepting reg_clk edge, provided writes are spaced at least ten smp_clk cycles apart.
- R6: A sample presented with in_valid high at a rising edge of smp_clk appears on the second rising edge, counting the accepting edge. At that edge out_valid is high. out_valid is low on that edge when in_valid was low at the accepting edge, and out_valid is low after reset.
- R7: The 32-bit signed product of sample and scale is shifted right by 14 with rounding to nearest, where an exact half rounds toward positive infinity.
- R8: A rounded result above 32767 is output as 32767 (0x7FFF), and a result below -32768 is output as -32768 (0x8000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| reg_clk | input | 1 | Register-side clock |
| reg_rst_n | input | 1 | Synchronous active-low reset, register domain |
| reg_wr | input | 1 | Write strobe for the scale word |
| reg_wdata | input | 16 | Scale word, sign-magnitude 1.1.14 |
| smp_clk | input | 1 | Sample clock |
| smp_rst_n | input | 1 | Synchronous active-low reset, sample domain |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 16 | Full-scale signed input sample |
| out_valid | output | 1 | Output sample qualifier |
| out_sample | output | 16 | Scaled, rounded, saturated sample |

## Verification
The bench targets the following corner cases:

- **Sign handling.** The word 0xA000 must give exactly half amplitude with the sign inverted. A design that only flipped the sign bit would output a large wrong value.
- **Negative zero.** The word 0x8000 must silence the output. A converter that negated the value would produce a full-scale negative scale.
- **Rounding at exact halves.** These are tested in both signs, where +1.5 must give 2 and -1.5 must give -1. Truncation or round-half-away-from-zero would miss one of them by one.
- **Saturation at both ends.** The largest positive and negative scale words are applied to large samples. Without saturation, the output wraps to the opposite sign.
- **Latency and valid alignment.** Off-cycle checks of out_valid catch a pipeline that is one stage short or long.

// File: rtl/amp_scale_pkg.sv
// Shared widths for the amplitude scaling stage.
// Assumes the sample and scale words are both 16 bits with 14 fraction bits.
package amp_scale_pkg;
    localparam int unsigned SAMPLE_W_DEF = 16;
    localparam int unsigned SCALE_W_DEF  = 16;
    localparam int unsigned FRAC_W_DEF   = 14;
    localparam int unsigned SYNC_N_DEF   = 2;
endpackage

// File: rtl/amp_scale_sm2tc.sv
// Register-domain scale holder. It converts a sign-magnitude word to two's
// complement when written and flips a toggle flag for every write.
// Assumes that writes are rare compared with the sample clock.
module amp_scale_sm2tc #(
    parameter int unsigned SCALE_W = amp_scale_pkg::SCALE_W_DEF,
    parameter int unsigned FRAC_W  = amp_scale_pkg::FRAC_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [SCALE_W-1:0] wdata,
    output logic [SCALE_W-1:0] scale_tc,
    output logic               toggle
);
    localparam logic [SCALE_W-1:0] UNITY = SCALE_W'(1) << FRAC_W;
    localparam logic [SCALE_W-1:0] NEG_ZERO = {1'b1, {(SCALE_W-1){1'b0}}};

    logic [SCALE_W-1:0] mag_ext;
    logic [SCALE_W-1:0] conv;

    // Negate the zero-extended magnitude when the sign bit is set.
    always_comb begin
        mag_ext = {1'b0, wdata[SCALE_W-2:0]};
        conv    = wdata[SCALE_W-1] ? (~mag_ext + 1'b1) : mag_ext;
    end

    // Capture the converted word and announce it with a toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scale_tc <= UNITY;
            toggle   <= 1'b0;
        end else if (wr) begin
            scale_tc <= conv;
            toggle   <= ~toggle;
        end
    end

    AST_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (wr && wdata == NEG_ZERO) |=> scale_tc == '0); // R2
    AST_SIGN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (wr && (|wdata[SCALE_W-2:0])) |=> scale_tc[SCALE_W-1] == $past(wdata[SCALE_W-1])); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !wr |=> $stable(scale_tc)); // R3
endmodule

// File: rtl/amp_scale_cdc.sv
// Carries the scale word into the sample domain. A synchronized toggle
// triggers a single load of the whole word.
// Assumes the source word stays stable for several sample cycles after each toggle.
module amp_scale_cdc #(
    parameter int unsigned SCALE_W = amp_scale_pkg::SCALE_W_DEF,
    parameter int unsigned FRAC_W  = amp_scale_pkg::FRAC_W_DEF,
    parameter int unsigned SYNC_N  = amp_scale_pkg::SYNC_N_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SCALE_W-1:0] src_scale,
    input  logic               src_toggle,
    output logic [SCALE_W-1:0] scale_q
);
    localparam logic [SCALE_W-1:0] UNITY = SCALE_W'(1) << FRAC_W;

    logic [SYNC_N:0] tsync;
    logic            load;

    // Synchronizer chain plus one extra stage used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tsync <= '0;
        else        tsync <= {tsync[SYNC_N-1:0], src_toggle};
    end

    // A change on the synchronized toggle marks a new word.
    always_comb load = tsync[SYNC_N] ^ tsync[SYNC_N-1];

    // Load the whole word in one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    scale_q <= UNITY;
        else if (load) scale_q <= src_scale;
    end

    AST_LOAD_WHOLE: assert property (@(posedge clk) disable iff (!rst_n) load |=> scale_q == $past(src_scale)); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) (tsync[SYNC_N] == tsync[SYNC_N-1]) |=> $stable(scale_q)); // R5
endmodule

// File: rtl/amp_scale_mult.sv
// Two-stage signed multiply. Stage one registers the full product. Stage two
// rounds, shifts and saturates it to the sample width. A valid flag follows each sample.
// Assumes both operands are two's complement.
module amp_scale_mult #(
    parameter int unsigned SAMPLE_W = amp_scale_pkg::SAMPLE_W_DEF,
    parameter int unsigned SCALE_W  = amp_scale_pkg::SCALE_W_DEF,
    parameter int unsigned FRAC_W   = amp_scale_pkg::FRAC_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SCALE_W-1:0]  scale,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample
);
    localparam int unsigned PW = SAMPLE_W + SCALE_W;
    localparam logic signed [PW:0] HALF   = (PW+1)'(1) <<< (FRAC_W-1);
    localparam logic signed [PW:0] MAXV   = (PW+1)'((1 << (SAMPLE_W-1)) - 1);
    localparam logic signed [PW:0] MINV   = -((PW+1)'(1) <<< (SAMPLE_W-1));
    localparam logic signed [PW:0] SAT_HI = (MAXV <<< FRAC_W) + HALF;
    localparam logic signed [PW:0] SAT_LO = (MINV <<< FRAC_W) - HALF;

    logic signed [PW-1:0]   prod_q;
    logic                   v1;
    logic signed [PW:0]     rnd;
    logic signed [PW:0]     shf;
    logic [SAMPLE_W-1:0]    sat_val;

    // Stage one: register the signed product and the qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            v1     <= 1'b0;
        end else begin
            prod_q <= $signed(in_sample) * $signed(scale);
            v1     <= in_valid;
        end
    end

    // Round half up, shift back to sample scale and clamp.
    always_comb begin
        rnd = $signed({prod_q[PW-1], prod_q}) + HALF;
        shf = rnd >>> FRAC_W;
        if (shf > MAXV)      sat_val = MAXV[SAMPLE_W-1:0];
        else if (shf < MINV) sat_val = MINV[SAMPLE_W-1:0];
        else                 sat_val = shf[SAMPLE_W-1:0];
    end

    // Stage two: register the final sample and qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid  <= v1;
            out_sample <= sat_val;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> ##1 out_valid); // R6
    AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ##1 !out_valid); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (v1 && ($signed({prod_q[PW-1], prod_q}) >= SAT_HI)) |=> out_sample == MAXV[SAMPLE_W-1:0]); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (v1 && ($signed({prod_q[PW-1], prod_q}) < SAT_LO)) |=> out_sample == MINV[SAMPLE_W-1:0]); // R8
endmodule

// File: rtl/amp_scale_stage.sv
// Top of the amplitude scaling stage. It contains the register-domain
// conversion, the scale transfer into the sample domain and the multiply pipeline.
// Assumes the two resets are each synchronous to their own clock.
module amp_scale_stage #(
    parameter int unsigned SAMPLE_W = amp_scale_pkg::SAMPLE_W_DEF,
    parameter int unsigned SCALE_W  = amp_scale_pkg::SCALE_W_DEF,
    parameter int unsigned FRAC_W   = amp_scale_pkg::FRAC_W_DEF,
    parameter int unsigned SYNC_N   = amp_scale_pkg::SYNC_N_DEF
) (
    input  logic                reg_clk,
    input  logic                reg_rst_n,
    input  logic                reg_wr,
    input  logic [SCALE_W-1:0]  reg_wdata,
    input  logic                smp_clk,
    input  logic                smp_rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample
);
    logic [SCALE_W-1:0] scale_reg;
    logic               scale_tgl;
    logic [SCALE_W-1:0] scale_smp;

    amp_scale_sm2tc #(.SCALE_W(SCALE_W), .FRAC_W(FRAC_W)) conv_i (
        .clk(reg_clk), .rst_n(reg_rst_n), .wr(reg_wr), .wdata(reg_wdata),
        .scale_tc(scale_reg), .toggle(scale_tgl)
    );

    amp_scale_cdc #(.SCALE_W(SCALE_W), .FRAC_W(FRAC_W), .SYNC_N(SYNC_N)) xfer_i (
        .clk(smp_clk), .rst_n(smp_rst_n), .src_scale(scale_reg),
        .src_toggle(scale_tgl), .scale_q(scale_smp)
    );

    amp_scale_mult #(.SAMPLE_W(SAMPLE_W), .SCALE_W(SCALE_W), .FRAC_W(FRAC_W)) mul_i (
        .clk(smp_clk), .rst_n(smp_rst_n), .scale(scale_smp),
        .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_sample(out_sample)
    );
endmodule

// File: tb/amp_scale_stage_tb_top.sv
module amp_scale_stage_tb_top;
    logic        reg_clk = 1'b0;
    logic        smp_clk = 1'b0;
    logic        reg_rst_n = 1'b0;
    logic        smp_rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        out_valid;
    logic [15:0] out_sample;

    int checks = 0;
    int fails  = 0;
    logic [15:0] cur_word = 16'h4000;

    always #2.5 smp_clk = ~smp_clk;
    always #5.0 reg_clk = ~reg_clk;

    amp_scale_stage dut_i (
        .reg_clk(reg_clk), .reg_rst_n(reg_rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .smp_clk(smp_clk), .smp_rst_n(smp_rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    // Expected output from the requirements: sign-magnitude scale, round half up, clamp.
    function automatic int model(input logic [15:0] w, input int s);
        longint m = longint'(w[14:0]);
        longint sc = w[15] ? -m : m;
        longint p = longint'(s) * sc;
        longint q = (p + 64'sd8192) >>> 14;
        if (q > 32767)  q = 32767;
        if (q < -32768) q = -32768;
        return int'(q);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_scale(input logic [15:0] w);
        @(negedge reg_clk);
        reg_wr = 1'b1; reg_wdata = w;
        @(negedge reg_clk);
        reg_wr = 1'b0;
        cur_word = w;
        repeat (10) @(posedge smp_clk);
    endtask

    // Send one sample and check latency, valid and value.
    task automatic send(input string req, input int s);
        int exp;
        exp = model(cur_word, s);
        @(negedge smp_clk);
        in_valid = 1'b1; in_sample = 16'(s);
        @(posedge smp_clk);
        @(negedge smp_clk);
        in_valid = 1'b0;
        check({req, " R6 valid not early"}, int'(out_valid), 0);
        @(posedge smp_clk);
        #1;
        check({req, " R6 valid on second edge"}, int'(out_valid), 1);
        check(req, int'($signed(out_sample)), exp);
    endtask

    task automatic test_reset;
        check("R6 out_valid low after reset", int'(out_valid), 0);
        send("R4 unity pass-through", 1234);
        send("R4 unity pass-through min", -32768);
    endtask

    task automatic test_idle;
        @(negedge smp_clk);
        in_valid = 1'b0; in_sample = 16'h1234;
        repeat (3) begin
            @(negedge smp_clk);
            check("R6 no valid without input", int'(out_valid), 0);
        end
    endtask

    task automatic test_signs;
        write_scale(16'hA000);
        send("R1 R5 half negative scale", 10000);
        send("R1 half negative scale neg sample", -7000);
        write_scale(16'h2000);
        send("R1 R3 half positive scale", 10000);
    endtask

    task automatic test_neg_zero;
        write_scale(16'h8000);
        send("R2 negative zero", 30000);
        send("R2 negative zero min", -32768);
    endtask

    task automatic test_round;
        write_scale(16'h2000);
        send("R7 plus 1.5 rounds to 2", 3);
        send("R7 minus 1.5 rounds to -1", -3);
        send("R7 minus 2.5 rounds to -2", -5);
    endtask

    task automatic test_sat;
        write_scale(16'h7FFF);
        send("R8 positive saturation", 30000);
        send("R8 negative saturation", -30000);
        write_scale(16'hFFFF);
        send("R8 negative scale saturation", 30000);
        send("R8 negative scale positive saturation", -30000);
        send("R1 largest negative scale small", 100);
    endtask

    initial begin
        #200_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge reg_clk);
        @(negedge smp_clk);
        reg_rst_n = 1'b1;
        smp_rst_n = 1'b1;
        @(negedge smp_clk);
        test_reset();
        test_idle();
        test_signs();
        test_neg_zero();
        test_round();
        test_sat();
        repeat (4) @(posedge smp_clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule